// File: doc/BRIEF.md
# Section Parity Byte Generator

This block sits in the transmit path of a byte-serial synchronous optical frame stream. Each byte arrives with a valid flag, a frame-start strobe on the first byte of a frame, and the keystream byte from an external frame scrambler. The block applies the keystream, writes parity bytes into their reserved overhead slots, and forwards the scrambled stream one cycle later. All parity is taken over the scrambled bytes that leave the block.

Two kinds of parity are produced. The whole-frame parity is one 8-bit bit-interleaved parity over every byte of a frame. The line parity is a set of 8-bit interleaved parities, one for each STS-1 column group. It covers only the rows below the first few section-overhead rows. The parity gathered over frame N is written into frame N+1. Row and column positions come from parameters, and an internal position tracker restarts at each frame-start strobe.

A small control word selects which parities are inserted. It also arms a one-frame parity inversion for testing downstream error counters, and it can leave the parity bytes or the framing-pattern bytes unscrambled.

Top module: `bip_parity_gen`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `ctl_rdata` reads 6'b000011, so both insertions are enabled and every other control bit is clear.
- R2: `out_valid` and `out_sof` follow `in_valid` and `in_valid && in_sof` one cycle later. Any byte outside an active overhead slot leaves as `in_data ^ in_key` on the cycle after it is accepted.
- R3: In the first frame after reset, the inserted whole-frame and line parity values are zero, so those slots carry only the keystream.
- R4: When control bit 0 is set, the byte at row B1_ROW, column B1_COL carries the XOR of all output bytes of the previous frame before it is scrambled. The accumulator keeps running while insertion is disabled.
- R5: When control bit 1 is set, the N_STS bytes at row B2_ROW starting at column B2_COL carry the previous frame's line parities. Byte k is the XOR of the output bytes in rows at or below RS_ROWS (rows counted from 0) whose column index mod N_STS equals k.
- R6: A write to `ctl_wdata` stores bits 0, 1, 4 and 5, and they read back on `ctl_rdata` from the next cycle. A slot whose insertion bit is 0 passes `in_data ^ in_key` unchanged.
- R7: Writing 1 to bit 2 (whole-frame) or bit 3 (line) inverts every bit of that inserted parity for exactly the next frame. A write on the same cycle as a frame start applies to the frame that is starting. The read-back bit is 1 from the write until the frame start that ends the inverted frame, and then returns to 0 by itself.
- R8: With control bit 4 set, inserted parity bytes leave without the keystream applied.
- R9: With control bit 5 set, the framing-pattern bytes (row 0, columns below 3*N_STS) leave without the keystream applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_data | input | 8 | Unscrambled input byte |
| in_key | input | 8 | Scrambler keystream byte for this position |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| ctl_rdata | output | 6 | Control word read-back |
| out_valid | output | 1 | Output byte is valid |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_data | output | 8 | Scrambled output byte with parity inserted |

## Verification
A control write and a frame start can land on the same cycle. Both then compete for the one-frame inversion latch: the start wants to promote the armed bit, and the write wants to arm it. The bench drives an inversion write on the exact byte that carries the frame-start strobe. It then checks that the whole-frame parity of that same frame arrives inverted. Read-back checks after that frame and after the following frame start show the bit still set and then cleared.

// File: rtl/bip_pkg.sv
package bip_pkg;
   localparam int BYTE_W = 8;
   localparam int CTL_W  = 6;

   typedef struct packed {
      logic a1_scr_off;
      logic par_scr_off;
      logic b2_inv;
      logic b1_inv;
      logic b2_en;
      logic b1_en;
   } ctl_t;

   localparam ctl_t CTL_RESET = ctl_t'(6'b000011);
endpackage

// File: rtl/bip_pos_tracker.sv
module bip_pos_tracker #(
   parameter int ROWS = 9,
   parameter int COLS = 90,
   parameter int GRPS = 1,
   parameter int RW   = 4,
   parameter int CW   = 7,
   parameter int GW   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          sof,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col,
   output logic [GW-1:0] grp,
   output logic          pos_ok
);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
   localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
   localparam logic [GW-1:0] LAST_GRP = GW'(GRPS - 1);

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic [GW-1:0] grp_q;
   logic          seen_q;

   // position of the byte presented this cycle
   always_comb begin
      row    = sof ? '0 : row_q;
      col    = sof ? '0 : col_q;
      grp    = sof ? '0 : grp_q;
      pos_ok = sof | seen_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         grp_q  <= '0;
         seen_q <= 1'b0;
      end else if (valid) begin
         seen_q <= seen_q | sof;
         if (col == LAST_COL) begin
            col_q <= '0;
            grp_q <= '0;
            row_q <= (row == LAST_ROW) ? '0 : row + 1'b1;
         end else begin
            col_q <= col + 1'b1;
            grp_q <= (grp == LAST_GRP) ? '0 : grp + 1'b1;
            row_q <= row;
         end
      end
   end
endmodule

// File: rtl/bip_ctl_regs.sv
module bip_ctl_regs
   import bip_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   input  logic             frame_start,
   output ctl_t             cfg,
   output logic             inv1_act,
   output logic             inv2_act,
   output logic [CTL_W-1:0] rdata
);
   ctl_t  wr;
   ctl_t  cfg_q;
   logic  arm1_q, arm2_q, act1_q, act2_q;

   assign wr = ctl_t'(wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= CTL_RESET;
         arm1_q <= 1'b0;
         arm2_q <= 1'b0;
         act1_q <= 1'b0;
         act2_q <= 1'b0;
      end else begin
         if (we) begin
            cfg_q.b1_en       <= wr.b1_en;
            cfg_q.b2_en       <= wr.b2_en;
            cfg_q.par_scr_off <= wr.par_scr_off;
            cfg_q.a1_scr_off  <= wr.a1_scr_off;
         end
         if (frame_start) begin
            // a write on the starting byte wins over an older arm
            act1_q <= we ? wr.b1_inv : arm1_q;
            act2_q <= we ? wr.b2_inv : arm2_q;
            arm1_q <= 1'b0;
            arm2_q <= 1'b0;
         end else if (we) begin
            arm1_q <= wr.b1_inv;
            arm2_q <= wr.b2_inv;
         end
      end
   end

   always_comb begin
      cfg        = cfg_q;
      cfg.b1_inv = arm1_q | act1_q;
      cfg.b2_inv = arm2_q | act2_q;
      inv1_act   = act1_q;
      inv2_act   = act2_q;
      rdata      = cfg;
   end
endmodule

// File: rtl/bip_lane_acc.sv
module bip_lane_acc #(
   parameter int LANES = 1,
   parameter int LW    = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  valid,
   input  logic                  start,
   input  logic                  hit,
   input  logic [LW-1:0]         sel,
   input  logic [7:0]            din,
   output logic [LANES-1:0][7:0] prev
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] acc_q;
      logic [7:0] prev_q;
      logic       mine;

      assign mine    = hit && (sel == LW'(l));
      assign prev[l] = prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q  <= '0;
            prev_q <= '0;
         end else if (valid && start) begin
            prev_q <= acc_q;
            acc_q  <= mine ? din : 8'h00;
         end else if (valid && mine) begin
            acc_q  <= acc_q ^ din;
         end
      end
   end
endmodule

// File: rtl/bip_parity_gen.sv
module bip_parity_gen
   import bip_pkg::*;
#(
   parameter int N_STS        = 1,
   parameter int COLS_PER_STS = 90,
   parameter int ROWS         = 9,
   parameter int RS_ROWS      = 3,
   parameter int B1_ROW       = 1,
   parameter int B1_COL       = 0,
   parameter int B2_ROW       = 4,
   parameter int B2_COL       = 0,
   parameter int A1_PER_STS   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic [7:0]       in_data,
   input  logic [7:0]       in_key,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             out_valid,
   output logic             out_sof,
   output logic [7:0]       out_data
);
   localparam int COLS = N_STS * COLS_PER_STS;
   localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int GW   = (N_STS > 1) ? $clog2(N_STS) : 1;

   localparam logic [RW-1:0] R_B1    = RW'(B1_ROW);
   localparam logic [CW-1:0] C_B1    = CW'(B1_COL);
   localparam logic [RW-1:0] R_B2    = RW'(B2_ROW);
   localparam logic [CW:0]   C_B2LO  = (CW+1)'(B2_COL);
   localparam logic [CW:0]   C_B2HI  = (CW+1)'(B2_COL + N_STS);
   localparam logic [RW-1:0] R_MS    = RW'(RS_ROWS);
   localparam logic [CW:0]   C_A1END = (CW+1)'(A1_PER_STS * N_STS);

   if (N_STS < 1 || COLS_PER_STS < 1) begin : g_bad_size
      $error("bip_parity_gen: frame size must be positive");
   end
   if (RS_ROWS < 1 || RS_ROWS >= ROWS) begin : g_bad_rs
      $error("bip_parity_gen: RS_ROWS must leave line rows");
   end
   if (B1_ROW < 1 || B1_ROW >= ROWS || B1_COL >= COLS) begin : g_bad_b1
      $error("bip_parity_gen: whole-frame parity slot out of range");
   end
   if (B2_ROW < RS_ROWS || B2_ROW >= ROWS || B2_COL + N_STS > COLS || (B2_COL % N_STS) != 0) begin : g_bad_b2
      $error("bip_parity_gen: line parity slot out of range or misaligned");
   end
   if (A1_PER_STS * N_STS > COLS) begin : g_bad_a1
      $error("bip_parity_gen: framing field wider than a row");
   end

   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic [GW-1:0] grp;
   logic          pos_ok;
   logic          start;
   ctl_t          cfg;
   logic          inv1, inv2;
   logic [0:0][7:0]       b1_prev;
   logic [N_STS-1:0][7:0] b2_prev;

   assign start = in_valid & in_sof;

   bip_pos_tracker #(
      .ROWS(ROWS), .COLS(COLS), .GRPS(N_STS), .RW(RW), .CW(CW), .GW(GW)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .sof(in_sof),
      .row(row), .col(col), .grp(grp), .pos_ok(pos_ok)
   );

   bip_ctl_regs u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .frame_start(start), .cfg(cfg), .inv1_act(inv1), .inv2_act(inv2),
      .rdata(ctl_rdata)
   );

   // slot decode
   logic is_b1, is_b2, is_a1, in_ms;
   logic ins_b1, ins_b2, key_off;
   logic [7:0] raw, scr;

   always_comb begin
      is_b1  = pos_ok && (row == R_B1) && (col == C_B1);
      is_b2  = pos_ok && (row == R_B2) && ({1'b0, col} >= C_B2LO) && ({1'b0, col} < C_B2HI);
      is_a1  = pos_ok && (row == '0) && ({1'b0, col} < C_A1END);
      in_ms  = pos_ok && (row >= R_MS);
      ins_b1 = is_b1 && cfg.b1_en;
      ins_b2 = is_b2 && cfg.b2_en;
      if (ins_b1)      raw = b1_prev[0] ^ {8{inv1}};
      else if (ins_b2) raw = b2_prev[grp] ^ {8{inv2}};
      else             raw = in_data;
      key_off = ((ins_b1 || ins_b2) && cfg.par_scr_off) || (is_a1 && cfg.a1_scr_off);
      scr     = raw ^ (key_off ? 8'h00 : in_key);
   end

   // whole-frame parity: one lane, every byte
   bip_lane_acc #(.LANES(1), .LW(1)) u_b1 (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .start(start),
      .hit(pos_ok), .sel(1'b0), .din(scr), .prev(b1_prev)
   );

   // line parity: one lane per column group, line rows only
   bip_lane_acc #(.LANES(N_STS), .LW(GW)) u_b2 (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .start(start),
      .hit(in_ms), .sel(grp), .din(scr), .prev(b2_prev)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= start;
         if (in_valid) out_data <= scr;
      end
   end
endmodule

// File: rtl/bip_parity_gen_chk.sv
module bip_parity_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sof,
   input logic       ctl_we,
   input logic [5:0] ctl_wdata,
   input logic [5:0] ctl_rdata,
   input logic       out_valid,
   input logic       out_sof
);
   AST_SOF_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> out_sof) else $error("sof not forwarded"); // R2
   AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("spurious valid"); // R2
   AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid) else $error("sof without valid"); // R2
   AST_FIELD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (ctl_rdata[1:0] == $past(ctl_wdata[1:0])) && (ctl_rdata[5:4] == $past(ctl_wdata[5:4])))
      else $error("control field not stored"); // R6
   AST_INV_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[2]) |=> ctl_rdata[2]) else $error("inversion not armed"); // R7
   AST_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !(in_valid && in_sof)) |=> $stable(ctl_rdata)) else $error("control moved"); // R7
endmodule

bind bip_parity_gen bip_parity_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
   .out_valid(out_valid), .out_sof(out_sof)
);

// File: tb/bip_parity_gen_tb.sv
module bip_parity_gen_tb;
   localparam int NS   = 2;
   localparam int CPS  = 4;
   localparam int NR   = 6;
   localparam int NC   = NS * CPS;
   localparam int FLEN = NR * NC;

   // {expected read-back, control write, data seed, key seed}
   localparam logic [27:0] TBL [7] = '{
      {6'h03, 6'h03, 8'h11, 8'h5A},
      {6'h03, 6'h03, 8'h27, 8'hC3},
      {6'h0F, 6'h0F, 8'h90, 8'h3C},
      {6'h0F, 6'h03, 8'h4E, 8'hA5},
      {6'h13, 6'h13, 8'h08, 8'h77},
      {6'h20, 6'h20, 8'hD1, 8'h19},
      {6'h03, 6'h03, 8'h62, 8'hE8}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sof = 1'b0;
   logic [7:0] in_data = '0, in_key = '0;
   logic       ctl_we = 1'b0;
   logic [5:0] ctl_wdata = '0;
   logic [5:0] ctl_rdata;
   logic       out_valid, out_sof;
   logic [7:0] out_data;

   int total = 0, bad = 0;

   always #10 clk = ~clk;

   bip_parity_gen #(
      .N_STS(NS), .COLS_PER_STS(CPS), .ROWS(NR), .RS_ROWS(3),
      .B1_ROW(1), .B1_COL(0), .B2_ROW(4), .B2_COL(0), .A1_PER_STS(3)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .in_key(in_key), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
   );

   // model state
   int         m_row = 0, m_col = 0, m_frames = 0;
   bit         m_seen = 0;
   logic [7:0] m_b1acc = 0, m_b1prev = 0;
   logic [7:0] m_b2acc [NS];
   logic [7:0] m_b2prev [NS];
   bit m_en1 = 1, m_en2 = 1, m_poff = 0, m_aoff = 0;
   bit m_arm1 = 0, m_arm2 = 0, m_act1 = 0, m_act2 = 0;

   function automatic logic [5:0] m_rd();
      return {m_aoff, m_poff, m_arm2 | m_act2, m_arm1 | m_act1, m_en2, m_en1};
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive_byte(bit sof, logic [7:0] d, logic [7:0] k, bit we, logic [5:0] wd);
      bit is_b1, is_b2, is_a1, ins1, ins2, koff;
      logic [7:0] raw, exp;
      string tag;
      in_valid = 1'b1; in_sof = sof; in_data = d; in_key = k;
      ctl_we = we; ctl_wdata = wd;
      if (sof) begin
         m_row = 0; m_col = 0; m_seen = 1;
         m_b1prev = m_b1acc; m_b1acc = '0;
         for (int g = 0; g < NS; g++) begin m_b2prev[g] = m_b2acc[g]; m_b2acc[g] = '0; end
      end
      is_b1 = m_seen && m_row == 1 && m_col == 0;
      is_b2 = m_seen && m_row == 4 && m_col < NS;
      is_a1 = m_seen && m_row == 0 && m_col < 3 * NS;
      ins1 = is_b1 && m_en1;
      ins2 = is_b2 && m_en2;
      if (ins1)      raw = m_b1prev ^ {8{m_act1}};
      else if (ins2) raw = m_b2prev[m_col] ^ {8{m_act2}};
      else           raw = d;
      koff = ((ins1 || ins2) && m_poff) || (is_a1 && m_aoff);
      exp  = raw ^ (koff ? 8'h00 : k);
      if ((ins1 && m_act1) || (ins2 && m_act2)) tag = "R7";
      else if ((ins1 || ins2) && m_poff)        tag = "R8";
      else if ((ins1 || ins2) && m_frames == 0) tag = "R3";
      else if (ins1)                            tag = "R4";
      else if (ins2)                            tag = "R5";
      else if (is_b1 || is_b2)                  tag = "R6";
      else if (is_a1 && m_aoff)                 tag = "R9";
      else                                      tag = "R2";
      if (m_seen) begin
         m_b1acc ^= exp;
         if (m_row >= 3) m_b2acc[m_col % NS] ^= exp;
      end
      if (we) begin
         m_en1 = wd[0]; m_en2 = wd[1]; m_poff = wd[4]; m_aoff = wd[5];
      end
      if (sof) begin
         m_act1 = we ? wd[2] : m_arm1; m_act2 = we ? wd[3] : m_arm2;
         m_arm1 = 0; m_arm2 = 0;
      end else if (we) begin
         m_arm1 = wd[2]; m_arm2 = wd[3];
      end
      if (m_col == NC - 1) begin m_col = 0; m_row = (m_row == NR - 1) ? 0 : m_row + 1; end
      else m_col++;
      @(negedge clk);
      check({tag, " valid"}, {7'd0, out_valid}, 8'd1);
      check({tag, " data"}, out_data, exp);
      ctl_we = 1'b0;
   endtask

   task automatic send_frame(logic [7:0] ds, logic [7:0] ks, bit we0, logic [5:0] wd0);
      for (int i = 0; i < FLEN; i++)
         drive_byte(i == 0, 8'(ds + i * 37 + (i >> 2)), 8'(ks ^ (i * 11)), (i == 0) && we0, wd0);
      m_frames++;
   endtask

   task automatic idle_read(string tag, logic [5:0] exp_rd);
      in_valid = 1'b0; in_sof = 1'b0;
      @(negedge clk);
      check("R2 idle", {7'd0, out_valid}, 8'd0);
      check(tag, {2'b00, ctl_rdata}, {2'b00, exp_rd});
      check({tag, " model"}, {2'b00, m_rd()}, {2'b00, exp_rd});
   endtask

   task automatic ctl_write(logic [5:0] wd, logic [5:0] exp_rd);
      in_valid = 1'b0; in_sof = 1'b0;
      ctl_we = 1'b1; ctl_wdata = wd;
      m_en1 = wd[0]; m_en2 = wd[1]; m_poff = wd[4]; m_aoff = wd[5];
      m_arm1 = wd[2]; m_arm2 = wd[3];
      @(negedge clk);
      ctl_we = 1'b0;
      check("R6 R7 readback", {2'b00, ctl_rdata}, {2'b00, exp_rd});
      check("R2 idle", {7'd0, out_valid}, 8'd0);
   endtask

   initial begin
      for (int g = 0; g < NS; g++) begin m_b2acc[g] = '0; m_b2prev[g] = '0; end
      repeat (3) @(negedge clk);
      check("R1 valid", {7'd0, out_valid}, 8'd0);
      check("R1 ctl", {2'b00, ctl_rdata}, 8'h03);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after", {7'd0, out_valid}, 8'd0);

      for (int e = 0; e < 7; e++) begin
         ctl_write(TBL[e][21:16], TBL[e][27:22]);
         send_frame(TBL[e][15:8], TBL[e][7:0], 1'b0, 6'h00);
      end

      // write of inversion on the frame-start byte itself
      send_frame(8'hB3, 8'h6D, 1'b1, 6'h07);
      idle_read("R7 held", 6'h07);
      send_frame(8'h35, 8'h92, 1'b0, 6'h00);
      idle_read("R7 cleared", 6'h03);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20ns * 200000);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule